// File: doc/BRIEF.md
# Pixel Offset and Common-Mode Corrector

This block is a streaming correction stage for one readout channel of a pixel detector that is read row by row. Raw ADC samples arrive on a valid/ready input, each tagged with its row and column. The stage first removes a per-pixel offset taken from an on-chip table. It then removes a level shared by every pixel of the channel in that row, and sends the corrected samples out on a valid/ready output with their tags.

The shared level is the mean of the offset-corrected values of the row. That mean is only known once the last sample of the row has arrived, so the stage collects a complete row segment before it emits anything. While the stage is between rows, the offset table can be loaded through a plain write port. Both subtractions clamp to the unsigned sample range.

Top module: `pixcm_corrector`

## Requirements
- R1: After reset, `s_ready` is 1 and `m_valid` is 0.
- R2: The first correction is c1 = clamp(s_pix − off, 0, 2^DW−1). Here off is the table entry for the sample's row and column, read as a DW-bit two's-complement number.
- R3: The row level is floor(Σc1 / PIX) over the PIX samples of the row. PIX is a power of two.
- R4: Each output sample is clamp(c1 − level, 0, 2^DW−1), so an output never exceeds its c1.
- R5: `m_valid` stays 0 while a row is being collected. It goes to 1 in the cycle after the handshake of the row's last input. `s_ready` and `m_valid` are never both 1.
- R6: A row's outputs leave in input order. Each carries its input column as `m_col`, and every output carries the row tag of the row's first input.
- R7: While `m_valid` is 1 and `m_ready` is 0, `m_pix`, `m_col` and `m_row` hold their values.
- R8: A write with `cfg_we` = 1 stores `cfg_off` at entry `cfg_addr` = row·PIX + col. The write takes effect only while no row is partly collected or being emitted. At any other time it is ignored.
- R9: Each row's level depends only on that row's samples. No sum carries over between rows.
- R10: `s_ready` returns to 1 in the cycle after the handshake of a row's last output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Offset table write strobe |
| cfg_addr | input | RW+CW | Table entry, row·PIX + col |
| cfg_off | input | DW | Signed offset to store |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Stage accepts a sample |
| s_pix | input | DW | Raw ADC sample |
| s_row | input | RW | Row tag of the sample |
| s_col | input | CW | Column within the channel |
| m_valid | output | 1 | Output sample valid |
| m_ready | input | 1 | Downstream accepts a sample |
| m_pix | output | DW | Corrected sample |
| m_row | output | RW | Row tag of the output |
| m_col | output | CW | Column of the output |

## Verification
The first corrected sample of a row is due in the cycle after the last input handshake. The bench therefore samples at the falling edge right after the posedge that accepted the last sample, and expects `m_valid` high and `s_ready` low there. Each further output is due on the handshake edge after the previous one. The bench compares values at the falling edge before each handshake, and after every stall cycle it checks that the held values did not change. `s_ready` is checked at the falling edge after the final output handshake. An ignored table write is judged by the output of a later row that reads the entry it targeted.

// File: rtl/pixcm_pkg.sv
package pixcm_pkg;

  typedef enum logic {
    PH_FILL  = 1'b0,
    PH_DRAIN = 1'b1
  } pixcm_phase_t;

  // Clamp a signed integer into 0..hi.
  function automatic int clamp_span(input int v, input int hi);
    if (v < 0) return 0;
    if (v > hi) return hi;
    return v;
  endfunction

  // Saturating difference a - b into 0..hi.
  function automatic int sat_diff(input int a, input int b, input int hi);
    return clamp_span(a - b, hi);
  endfunction

endpackage

// File: rtl/pixcm_offset_table.sv
module pixcm_offset_table #(
  parameter int DW    = 14,
  parameter int DEPTH = 1024,
  parameter int AW    = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/pixcm_row_collect.sv
module pixcm_row_collect
  import pixcm_pkg::*;
#(
  parameter int DW  = 14,
  parameter int PIX = 64,
  parameter int CW  = 6,
  parameter int RW  = 4,
  parameter int SW  = DW + CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic [DW-1:0] c1_in,
  input  logic [CW-1:0] col_in,
  input  logic [RW-1:0] row_in,
  input  logic          release_row,
  input  logic [CW-1:0] rd_idx,
  output pixcm_phase_t  phase,
  output logic [CW-1:0] wr_cnt,
  output logic [RW-1:0] row_q,
  output logic [SW-1:0] sum_q,
  output logic [DW-1:0] rd_pix,
  output logic [CW-1:0] rd_col,
  output logic          last_acc
);
  logic [DW-1:0] pix_buf [PIX];
  logic [CW-1:0] col_buf [PIX];

  assign last_acc = acc && (wr_cnt == CW'(PIX - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= PH_FILL;
      wr_cnt <= '0;
      sum_q  <= '0;
      row_q  <= '0;
    end else if (acc) begin
      if (wr_cnt == '0) begin
        row_q <= row_in;
        sum_q <= SW'(c1_in);
      end else begin
        sum_q <= sum_q + SW'(c1_in);
      end
      if (last_acc) begin
        wr_cnt <= '0;
        phase  <= PH_DRAIN;
      end else begin
        wr_cnt <= wr_cnt + 1'b1;
      end
    end else if (release_row) begin
      phase <= PH_FILL;
    end
  end

  always_ff @(posedge clk) begin
    if (acc) begin
      pix_buf[wr_cnt] <= c1_in;
      col_buf[wr_cnt] <= col_in;
    end
  end

  assign rd_pix = pix_buf[rd_idx];
  assign rd_col = col_buf[rd_idx];
endmodule

// File: rtl/pixcm_row_emit.sv
module pixcm_row_emit
  import pixcm_pkg::*;
#(
  parameter int DW  = 14,
  parameter int PIX = 64,
  parameter int CW  = 6,
  parameter int SW  = DW + CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  pixcm_phase_t  phase,
  input  logic [SW-1:0] sum_q,
  input  logic [DW-1:0] rd_pix,
  input  logic [CW-1:0] rd_col,
  input  logic          m_ready,
  output logic [CW-1:0] rd_idx,
  output logic          m_valid,
  output logic [DW-1:0] m_pix,
  output logic [CW-1:0] m_col,
  output logic [DW-1:0] level,
  output logic          release_row
);
  localparam int MAXV = (1 << DW) - 1;

  logic fire;

  assign m_valid     = (phase == PH_DRAIN);
  assign fire        = m_valid && m_ready;
  assign release_row = fire && (rd_idx == CW'(PIX - 1));
  assign level       = DW'(sum_q >> CW);
  assign m_pix       = DW'(sat_diff(int'(rd_pix), int'(level), MAXV));
  assign m_col       = rd_col;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_idx <= '0;
    end else if (fire) begin
      rd_idx <= release_row ? '0 : rd_idx + 1'b1;
    end
  end
endmodule

// File: rtl/pixcm_corrector.sv
module pixcm_corrector
  import pixcm_pkg::*;
#(
  parameter int DW   = 14,
  parameter int PIX  = 64,
  parameter int ROWS = 16,
  parameter int CW   = $clog2(PIX),
  parameter int RW   = $clog2(ROWS),
  parameter int AW   = RW + CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [DW-1:0] cfg_off,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] s_pix,
  input  logic [RW-1:0] s_row,
  input  logic [CW-1:0] s_col,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [DW-1:0] m_pix,
  output logic [RW-1:0] m_row,
  output logic [CW-1:0] m_col
);
  localparam int SW    = DW + CW;
  localparam int DEPTH = ROWS * PIX;
  localparam int MAXV  = (1 << DW) - 1;

  pixcm_phase_t  phase;
  logic [CW-1:0] wr_cnt;
  logic [CW-1:0] rd_idx;
  logic [SW-1:0] sum_q;
  logic [DW-1:0] rd_pix;
  logic [CW-1:0] rd_col;
  logic [DW-1:0] off_rd;
  logic [DW-1:0] c1;
  logic [DW-1:0] level;
  logic          acc;
  logic          last_acc;
  logic          release_row;
  logic          tbl_we;
  logic          idle;

  assign idle    = (phase == PH_FILL) && (wr_cnt == '0);
  assign s_ready = (phase == PH_FILL);
  assign acc     = s_valid && s_ready;
  assign tbl_we  = cfg_we && idle;
  assign c1      = DW'(sat_diff(int'(s_pix), int'($signed(off_rd)), MAXV));

  pixcm_offset_table #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_tbl (
    .clk   (clk),
    .we    (tbl_we),
    .waddr (cfg_addr),
    .wdata (cfg_off),
    .raddr ({s_row, s_col}),
    .rdata (off_rd)
  );

  pixcm_row_collect #(.DW(DW), .PIX(PIX), .CW(CW), .RW(RW), .SW(SW)) u_col (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc         (acc),
    .c1_in       (c1),
    .col_in      (s_col),
    .row_in      (s_row),
    .release_row (release_row),
    .rd_idx      (rd_idx),
    .phase       (phase),
    .wr_cnt      (wr_cnt),
    .row_q       (m_row),
    .sum_q       (sum_q),
    .rd_pix      (rd_pix),
    .rd_col      (rd_col),
    .last_acc    (last_acc)
  );

  pixcm_row_emit #(.DW(DW), .PIX(PIX), .CW(CW), .SW(SW)) u_emit (
    .clk         (clk),
    .rst_n       (rst_n),
    .phase       (phase),
    .sum_q       (sum_q),
    .rd_pix      (rd_pix),
    .rd_col      (rd_col),
    .m_ready     (m_ready),
    .rd_idx      (rd_idx),
    .m_valid     (m_valid),
    .m_pix       (m_pix),
    .m_col       (m_col),
    .level       (level),
    .release_row (release_row)
  );
endmodule

// File: rtl/pixcm_corrector_chk.sv
module pixcm_corrector_chk #(
  parameter int DW = 14,
  parameter int RW = 4,
  parameter int CW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          s_ready,
  input logic          m_valid,
  input logic          m_ready,
  input logic [DW-1:0] m_pix,
  input logic [RW-1:0] m_row,
  input logic [CW-1:0] m_col,
  input logic          last_acc,
  input logic          release_row,
  input logic [DW-1:0] emit_src
);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_pix) && $stable(m_col) && $stable(m_row)));

  assert_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(s_ready && m_valid));

  assert_first_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
    last_acc |=> m_valid);

  assert_level_le_R4: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> (m_pix <= emit_src));

  assert_resume_R10: assert property (@(posedge clk) disable iff (!rst_n)
    release_row |=> (s_ready && !m_valid));

  assert_row_tag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !release_row) |=> $stable(m_row));
endmodule

bind pixcm_corrector pixcm_corrector_chk #(.DW(DW), .RW(RW), .CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .s_ready     (s_ready),
  .m_valid     (m_valid),
  .m_ready     (m_ready),
  .m_pix       (m_pix),
  .m_row       (m_row),
  .m_col       (m_col),
  .last_acc    (last_acc),
  .release_row (release_row),
  .emit_src    (rd_pix)
);

// File: tb/pixcm_corrector_test.sv
`timescale 1ns/1ps
module pixcm_corrector_test;
  localparam int DW   = 14;
  localparam int PIX  = 8;
  localparam int ROWS = 4;
  localparam int CW   = 3;
  localparam int RW   = 2;
  localparam int AW   = 5;
  localparam int TOP  = 16383;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [DW-1:0] cfg_off = '0;
  logic s_valid = 1'b0;
  logic s_ready;
  logic [DW-1:0] s_pix = '0;
  logic [RW-1:0] s_row = '0;
  logic [CW-1:0] s_col = '0;
  logic m_valid;
  logic m_ready = 1'b0;
  logic [DW-1:0] m_pix;
  logic [RW-1:0] m_row;
  logic [CW-1:0] m_col;

  int total = 0;
  int bad = 0;
  bit done = 0;
  int off_m [ROWS*PIX];
  int exp_o [PIX];

  always #2 clk = ~clk;

  pixcm_corrector #(.DW(DW), .PIX(PIX), .ROWS(ROWS)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_off(cfg_off),
    .s_valid(s_valid), .s_ready(s_ready), .s_pix(s_pix), .s_row(s_row), .s_col(s_col),
    .m_valid(m_valid), .m_ready(m_ready), .m_pix(m_pix), .m_row(m_row), .m_col(m_col)
  );

  task automatic chk(input string req, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int lim(input int v);
    int r;
    r = v;
    if (r > TOP) r = TOP;
    if (r < 0) r = 0;
    return r;
  endfunction

  function automatic int pat_val(input int pat, input int row, input int col);
    case (pat)
      0: return 0;
      1: return TOP;
      2: return col * 2000;
      3: return (row * 977 + col * 4513 + 31) % 16384;
      4: return (col % 2 == 1) ? TOP : 0;
      default: return 5000 + col * 7;
    endcase
  endfunction

  // Expected outputs of a row, derived from R2, R3 and R4.
  task automatic model_row(input int pat, input int row);
    int c1 [PIX];
    int acc_s;
    int lvl;
    acc_s = 0;
    for (int c = 0; c < PIX; c++) begin
      c1[c] = lim(pat_val(pat, row, c) - off_m[row*PIX + c]);
      acc_s += c1[c];
    end
    lvl = acc_s / PIX;
    for (int c = 0; c < PIX; c++) exp_o[c] = lim(c1[c] - lvl);
  endtask

  task automatic cfg_write(input int addr, input int val);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_addr = AW'(addr);
    cfg_off = DW'(val);
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send_row(input int pat, input int row, input bit gaps,
                          input bit poke, input int paddr, input int pval);
    for (int c = 0; c < PIX; c++) begin
      @(negedge clk);
      cfg_we = 1'b0;
      chk("R5 no output while collecting", int'(m_valid), 0);
      if (gaps && (c % 3 == 2)) begin
        s_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
      end
      if (poke && c == 3) begin
        s_valid = 1'b0;
        cfg_we = 1'b1;
        cfg_addr = AW'(paddr);
        cfg_off = DW'(pval);
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
      end
      s_valid = 1'b1;
      s_pix = DW'(pat_val(pat, row, c));
      s_row = RW'(row);
      s_col = CW'(c);
      @(posedge clk);
    end
    @(negedge clk);
    s_valid = 1'b0;
    chk("R5 m_valid one cycle after last input", int'(m_valid), 1);
    chk("R5 s_ready low while emitting", int'(s_ready), 0);
  endtask

  task automatic recv_row(input int row, input int bp,
                          input bit poke, input int paddr, input int pval);
    int held;
    if (poke) begin
      @(negedge clk);
      m_ready = 1'b0;
      cfg_we = 1'b1;
      cfg_addr = AW'(paddr);
      cfg_off = DW'(pval);
      @(posedge clk);
    end
    for (int i = 0; i < PIX; i++) begin
      @(negedge clk);
      cfg_we = 1'b0;
      if (bp != 0 && ((i + bp) % 3 == 0)) begin
        m_ready = 1'b0;
        held = int'(m_pix);
        @(posedge clk);
        @(negedge clk);
        chk("R7 value held under stall", int'(m_pix), held);
        chk("R7 column held under stall", int'(m_col), i);
      end
      m_ready = 1'b1;
      chk("R5 output valid", int'(m_valid), 1);
      chk("R2 R3 R4 R9 corrected pixel", int'(m_pix), exp_o[i]);
      chk("R6 column order", int'(m_col), i);
      chk("R6 row tag", int'(m_row), row);
      @(posedge clk);
    end
    @(negedge clk);
    m_ready = 1'b0;
    chk("R10 s_ready back after last output", int'(s_ready), 1);
    chk("R10 no output after row", int'(m_valid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 s_ready after reset", int'(s_ready), 1);
    chk("R1 m_valid after reset", int'(m_valid), 0);

    // R8: load the whole table at address row*PIX+col while idle.
    for (int a = 0; a < ROWS*PIX; a++) begin
      off_m[a] = ((a * 37) % 200) - 60;
      if (a == 8) off_m[a] = 8191;
      if (a == 9) off_m[a] = -8192;
      if (a == 20) off_m[a] = 300;
      cfg_write(a, off_m[a]);
    end

    // Sweep every pattern over every row (R2, R3, R4, R6, R9 clamps included).
    for (int p = 0; p < 6; p++) begin
      for (int r = 0; r < ROWS; r++) begin
        model_row(p, r);
        send_row(p, r, (r % 2) == 1, 1'b0, 0, 0);
        recv_row(r, (p + r) % 3, 1'b0, 0, 0);
      end
    end

    // R8: writes during collection and during emission are ignored.
    model_row(3, 1);
    send_row(3, 1, 1'b0, 1'b1, 2*PIX + 5, 1234);
    recv_row(1, 0, 1'b1, 2*PIX + 6, 4321);
    model_row(5, 2);
    send_row(5, 2, 1'b0, 1'b0, 0, 0);
    recv_row(2, 1, 1'b0, 0, 0);

    // R8: an idle write does take effect.
    off_m[2*PIX + 5] = -3000;
    cfg_write(2*PIX + 5, -3000);
    model_row(5, 2);
    send_row(5, 2, 1'b0, 1'b0, 0, 0);
    recv_row(2, 2, 1'b0, 0, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule